// File: doc/BRIEF.md
# Access-Map Stride Prefetcher

The block keeps a small table of recently touched 4 KB pages. Each tracked page carries a 64-bit map of lines that demand requests have touched, plus four per-line maps that record where a prefetch for that line has come from: issued into L2, issued into the last-level cache, covered by the neighbouring large-block logic, or covered by the neighbouring page-offset logic. Every accepted L2 request marks its line in the demand map. When the request missed, or hit a line that a prefetch had brought in, a sequential scan then looks for a stride that the demand map repeats twice. It scans forward first and backward second, testing one stride per cycle, and emits line-aligned prefetch requests on a valid/ready stream.

Each prefetch carries a fill target. L2 is chosen while the L2 miss-handling occupancy is low, and the last-level cache is chosen once that occupancy is high. The candidate filters consult all four source maps, so the block never requests a line that is already covered. A side input lets the neighbouring large-block and page-offset engines record their own coverage in the table. A per-request count of page-offset prefetches reduces how many requests the scan may issue in each direction.

Top module: `stride_map_prefetcher`

## Requirements
- R1: A request address splits into a page tag (bits ADDR_W-1 down to 12) and a line index (bits 11 to 6). Every accepted request sets its line in the demand map of its page. Every prefetch address lies in the page of the request that caused it, with address bits 5 to 0 at zero.
- R2: A request to an untracked page allocates the lowest-numbered empty entry. If no entry is empty, it allocates the entry whose last access is oldest. All five maps of the allocated entry start cleared. Any access to an entry refreshes its age.
- R3: A scan runs only when req_hit is 0, or when req_hit and req_was_pf are both 1. A hit with req_was_pf at 0 only updates the table and issues nothing.
- R4: The forward scan tests strides i = 1 to 16 in ascending order. The candidate is line+i, and it needs lines line-i and line-2i set in the demand map. The scan ends once line-2i < 0 or line+i > 63.
- R5: The backward scan follows the forward scan with the same stride order. The candidate is line-i, and it needs lines line+i and line+2i set in the demand map. The scan ends once line+2i > 63 or line-i < 0.
- R6: A candidate that is already set in the demand map or in the L2-prefetched map is passed over without a request.
- R7: A candidate already set in the page-offset map causes no request. Its L2-prefetched bit is set instead, so later scans pass over it.
- R8: pf_to_llc is 0 (fill L2) when mshr_occ < 12, and 1 (fill the last-level cache) when mshr_occ >= 12. A candidate set in the large-block map causes no request and has its last-level-cache bit set.
- R9: A candidate already in the last-level-cache map is not requested again while mshr_occ >= 12. With mshr_occ < 12 it is requested again with an L2 fill.
- R10: Each direction issues at most DEGREE - floor(req_po_cnt/2) requests. When that value is 0 or less, the direction issues none.
- R11: pf_addr holds steady while pf_valid is 1 and pf_ready is 0. A map bit for an issued line is set only in the cycle the request is accepted. Across a scan, requests appear in forward-then-backward, ascending-stride order.
- R12: req_ready is 1 when no scan is running and 0 while one is. It is 1 and pf_valid is 0 after reset.
- R13: A mark_valid pulse sets the mark_addr line in the large-block map when mark_page_ofs is 0, or in the page-offset map when mark_page_ofs is 1. A mark to an untracked page changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | L2 request observation valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Request byte address |
| req_hit | input | 1 | Request hit in L2 |
| req_was_pf | input | 1 | Hit line had been filled by a prefetch |
| req_po_cnt | input | PO_W | Page-offset prefetches issued for this request |
| mshr_occ | input | OCC_W | Current L2 miss-handling occupancy |
| mark_valid | input | 1 | Coverage mark from a neighbouring engine |
| mark_addr | input | ADDR_W | Address of the marked line |
| mark_page_ofs | input | 1 | 0 selects the large-block map, 1 the page-offset map |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Downstream takes the prefetch request |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |
| pf_to_llc | output | 1 | 1 fills the last-level cache, 0 fills L2 |

## Verification
An accepted request updates the table at the accepting edge. req_ready falls in the following cycle if a scan starts, and the first candidate is tested in that same cycle. The scan then tests one stride per cycle, taking at most 34 cycles plus one extra cycle for each stall on pf_ready, before req_ready returns. The bench therefore samples each handshake on the falling edge, collects every accepted prefetch, and waits until req_ready is high with pf_valid low. Only then does it compare the collected stream, in order, against a table model that applies the rules in program order. Marks and occupancy changes are applied only while the block is idle, so the model's one-step result equals the cycle-by-cycle scan.

// File: rtl/smp_pkg.sv
package smp_pkg;

    localparam int LINE_W        = 6;
    localparam int LINES         = 64;
    localparam int PAGE_SHIFT    = 12;
    localparam int MAX_STRIDE    = 16;
    localparam int STRIDE_W      = 5;
    localparam int OCC_LLC_LIMIT = 12;

    typedef logic [LINES-1:0] line_map_t;

    typedef struct packed {
        line_map_t acc;   // demand touched
        line_map_t l2;    // prefetched into L2
        line_map_t llc;   // prefetched into last-level cache
        line_map_t lb;    // covered by large-block engine
        line_map_t po;    // covered by page-offset engine
    } page_maps_t;

    typedef enum logic [1:0] {SCAN_IDLE, SCAN_FWD, SCAN_BWD} scan_state_e;

    typedef enum logic [2:0] {
        CAND_END, CAND_SKIP, CAND_ABSORB_L2, CAND_ABSORB_LLC, CAND_ISSUE
    } cand_act_e;

    typedef struct packed {
        logic              in_range;
        logic [LINE_W-1:0] cand;
        logic [LINE_W-1:0] ref1;
        logic [LINE_W-1:0] ref2;
    } stride_probe_t;

    function automatic stride_probe_t stride_probe(input logic [LINE_W-1:0] base,
                                                   input logic [STRIDE_W-1:0] step,
                                                   input logic fwd);
        stride_probe_t p;
        logic [7:0] b;
        logic [7:0] s;
        b = {2'b00, base};
        s = {3'b000, step};
        if (fwd) begin
            p.in_range = (b >= 8'(s << 1)) && ((b + s) <= 8'(LINES - 1));
            p.cand     = LINE_W'(b + s);
            p.ref1     = LINE_W'(b - s);
            p.ref2     = LINE_W'(b - 8'(s << 1));
        end else begin
            p.in_range = ((b + 8'(s << 1)) <= 8'(LINES - 1)) && (b >= s);
            p.cand     = LINE_W'(b - s);
            p.ref1     = LINE_W'(b + s);
            p.ref2     = LINE_W'(b + 8'(s << 1));
        end
        p.in_range = p.in_range && (s >= 8'd1) && (s <= 8'(MAX_STRIDE));
        return p;
    endfunction

endpackage

// File: rtl/smp_page_table.sv
module smp_page_table
    import smp_pkg::*;
#(
    parameter int N_PAGES = 64,
    parameter int TAG_W   = 20,
    parameter int TS_W    = 16,
    parameter int IDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [IDX_W-1:0]  victim_idx,
    input  logic [TAG_W-1:0]  mk_tag,
    output logic              mk_hit,
    output logic [IDX_W-1:0]  mk_idx,
    input  logic              touch_en,
    input  logic              touch_alloc,
    input  logic [IDX_W-1:0]  touch_idx,
    input  logic [LINE_W-1:0] touch_line,
    input  logic              mark_en,
    input  logic [IDX_W-1:0]  mark_idx,
    input  logic [LINE_W-1:0] mark_line,
    input  logic              mark_page_ofs,
    input  logic              scan_wr_en,
    input  logic [IDX_W-1:0]  scan_idx,
    input  logic [LINE_W-1:0] scan_line,
    input  logic              scan_wr_llc,
    output page_maps_t        scan_maps
);

    logic             valid_q [N_PAGES];
    logic [TAG_W-1:0] tag_q   [N_PAGES];
    logic [TS_W-1:0]  ts_q    [N_PAGES];
    page_maps_t       maps_q  [N_PAGES];
    logic [TS_W-1:0]  stamp_q;

    // tag match for requests and for marks
    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        mk_hit = 1'b0;
        mk_idx = '0;
        for (int k = 0; k < N_PAGES; k++) begin
            if (valid_q[k] && tag_q[k] == lk_tag && !lk_hit) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(k);
            end
            if (valid_q[k] && tag_q[k] == mk_tag && !mk_hit) begin
                mk_hit = 1'b1;
                mk_idx = IDX_W'(k);
            end
        end
    end

    // replacement: first empty entry, else oldest stamp
    logic             have_free, have_min;
    logic [IDX_W-1:0] free_idx, min_idx;
    logic [TS_W-1:0]  min_ts;
    always_comb begin
        have_free = 1'b0;
        have_min  = 1'b0;
        free_idx  = '0;
        min_idx   = '0;
        min_ts    = '0;
        for (int k = 0; k < N_PAGES; k++) begin
            if (!valid_q[k]) begin
                if (!have_free) begin
                    have_free = 1'b1;
                    free_idx  = IDX_W'(k);
                end
            end else if (!have_min || ts_q[k] < min_ts) begin
                have_min = 1'b1;
                min_idx  = IDX_W'(k);
                min_ts   = ts_q[k];
            end
        end
        victim_idx = have_free ? free_idx : min_idx;
    end

    assign scan_maps = maps_q[scan_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_q <= '0;
            for (int k = 0; k < N_PAGES; k++) begin
                valid_q[k] <= 1'b0;
                tag_q[k]   <= '0;
                ts_q[k]    <= '0;
                maps_q[k]  <= '0;
            end
        end else begin
            if (mark_en) begin
                if (mark_page_ofs) maps_q[mark_idx].po[mark_line] <= 1'b1;
                else               maps_q[mark_idx].lb[mark_line] <= 1'b1;
            end
            if (scan_wr_en) begin
                if (scan_wr_llc) maps_q[scan_idx].llc[scan_line] <= 1'b1;
                else             maps_q[scan_idx].l2[scan_line]  <= 1'b1;
            end
            if (touch_en) begin
                if (touch_alloc) begin
                    maps_q[touch_idx]  <= '0;
                    valid_q[touch_idx] <= 1'b1;
                    tag_q[touch_idx]   <= lk_tag;
                end
                maps_q[touch_idx].acc[touch_line] <= 1'b1;
                ts_q[touch_idx] <= stamp_q;
                stamp_q         <= stamp_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/smp_stride_scan.sv
module smp_stride_scan
    import smp_pkg::*;
#(
    parameter int TAG_W  = 20,
    parameter int IDX_W  = 6,
    parameter int DEGREE = 4,
    parameter int OCC_W  = 6,
    parameter int PO_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [TAG_W-1:0]         start_tag,
    input  logic [LINE_W-1:0]        start_line,
    input  logic [IDX_W-1:0]         start_idx,
    input  logic [PO_W-1:0]          start_po,
    input  page_maps_t               maps,
    input  logic [OCC_W-1:0]         occ,
    output logic                     busy,
    output logic [IDX_W-1:0]         ent_idx,
    output logic                     pf_valid,
    input  logic                     pf_ready,
    output logic [TAG_W+PAGE_SHIFT-1:0] pf_addr,
    output logic                     pf_to_llc,
    output logic                     wr_en,
    output logic [LINE_W-1:0]        wr_line,
    output logic                     wr_llc
);

    scan_state_e         state_q;
    logic [STRIDE_W-1:0] stride_q, issued_q;
    logic [LINE_W-1:0]   base_q;
    logic [TAG_W-1:0]    tag_q;
    logic [IDX_W-1:0]    idx_q;
    logic [PO_W-1:0]     po_q;

    stride_probe_t pr;
    cand_act_e     act;
    int            cap_i;
    logic          to_llc, active, step;

    always_comb begin
        pr     = stride_probe(base_q, stride_q, state_q == SCAN_FWD);
        cap_i  = DEGREE - int'(po_q >> 1);
        to_llc = int'(occ) >= OCC_LLC_LIMIT;
        if (!pr.in_range || int'(issued_q) >= cap_i)
            act = CAND_END;
        else if (!(maps.acc[pr.ref1] && maps.acc[pr.ref2]) ||
                 maps.acc[pr.cand] || maps.l2[pr.cand])
            act = CAND_SKIP;
        else if (maps.po[pr.cand])
            act = CAND_ABSORB_L2;
        else if (maps.lb[pr.cand])
            act = CAND_ABSORB_LLC;
        else if (to_llc && maps.llc[pr.cand])
            act = CAND_SKIP;
        else
            act = CAND_ISSUE;
    end

    assign active    = state_q != SCAN_IDLE;
    assign busy      = active;
    assign ent_idx   = idx_q;
    assign pf_valid  = active && act == CAND_ISSUE;
    assign pf_addr   = {tag_q, pr.cand, {(PAGE_SHIFT-LINE_W){1'b0}}};
    assign pf_to_llc = to_llc;
    assign step      = act != CAND_END && (act != CAND_ISSUE || pf_ready);
    assign wr_en     = active && (act == CAND_ABSORB_L2 || act == CAND_ABSORB_LLC ||
                                  (act == CAND_ISSUE && pf_ready));
    assign wr_line   = pr.cand;
    assign wr_llc    = act == CAND_ABSORB_LLC || (act == CAND_ISSUE && to_llc);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SCAN_IDLE;
            stride_q <= '0;
            issued_q <= '0;
            base_q   <= '0;
            tag_q    <= '0;
            idx_q    <= '0;
            po_q     <= '0;
        end else if (!active) begin
            if (start) begin
                state_q  <= SCAN_FWD;
                stride_q <= STRIDE_W'(1);
                issued_q <= '0;
                base_q   <= start_line;
                tag_q    <= start_tag;
                idx_q    <= start_idx;
                po_q     <= start_po;
            end
        end else if (act == CAND_END) begin
            state_q  <= (state_q == SCAN_FWD) ? SCAN_BWD : SCAN_IDLE;
            stride_q <= STRIDE_W'(1);
            issued_q <= '0;
        end else if (step) begin
            stride_q <= stride_q + 1'b1;
            if (act == CAND_ISSUE) issued_q <= issued_q + 1'b1;
        end
    end

endmodule

// File: rtl/stride_map_prefetcher.sv
module stride_map_prefetcher
    import smp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int N_PAGES = 64,
    parameter int DEGREE  = 4,
    parameter int OCC_W   = 6,
    parameter int PO_W    = 3,
    parameter int TS_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_hit,
    input  logic              req_was_pf,
    input  logic [PO_W-1:0]   req_po_cnt,
    input  logic [OCC_W-1:0]  mshr_occ,
    input  logic              mark_valid,
    input  logic [ADDR_W-1:0] mark_addr,
    input  logic              mark_page_ofs,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              pf_to_llc
);

    localparam int TAG_W = ADDR_W - PAGE_SHIFT;
    localparam int IDX_W = (N_PAGES > 1) ? $clog2(N_PAGES) : 1;

    logic              busy, accept, lk_hit, mk_hit, wr_en, wr_llc;
    logic [IDX_W-1:0]  lk_idx, victim_idx, mk_idx, ent_idx, touch_idx;
    logic [LINE_W-1:0] wr_line, req_line, mark_line;
    logic [TAG_W-1:0]  req_tag, mark_tag;
    page_maps_t        scan_maps;

    assign req_tag   = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign req_line  = req_addr[PAGE_SHIFT-1:PAGE_SHIFT-LINE_W];
    assign mark_tag  = mark_addr[ADDR_W-1:PAGE_SHIFT];
    assign mark_line = mark_addr[PAGE_SHIFT-1:PAGE_SHIFT-LINE_W];
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign touch_idx = lk_hit ? lk_idx : victim_idx;

    smp_page_table #(
        .N_PAGES(N_PAGES), .TAG_W(TAG_W), .TS_W(TS_W), .IDX_W(IDX_W)
    ) table_i (
        .clk          (clk),
        .rst          (rst),
        .lk_tag       (req_tag),
        .lk_hit       (lk_hit),
        .lk_idx       (lk_idx),
        .victim_idx   (victim_idx),
        .mk_tag       (mark_tag),
        .mk_hit       (mk_hit),
        .mk_idx       (mk_idx),
        .touch_en     (accept),
        .touch_alloc  (!lk_hit),
        .touch_idx    (touch_idx),
        .touch_line   (req_line),
        .mark_en      (mark_valid && mk_hit),
        .mark_idx     (mk_idx),
        .mark_line    (mark_line),
        .mark_page_ofs(mark_page_ofs),
        .scan_wr_en   (wr_en),
        .scan_idx     (ent_idx),
        .scan_line    (wr_line),
        .scan_wr_llc  (wr_llc),
        .scan_maps    (scan_maps)
    );

    smp_stride_scan #(
        .TAG_W(TAG_W), .IDX_W(IDX_W), .DEGREE(DEGREE), .OCC_W(OCC_W), .PO_W(PO_W)
    ) scan_i (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && (!req_hit || req_was_pf)),
        .start_tag (req_tag),
        .start_line(req_line),
        .start_idx (touch_idx),
        .start_po  (req_po_cnt),
        .maps      (scan_maps),
        .occ       (mshr_occ),
        .busy      (busy),
        .ent_idx   (ent_idx),
        .pf_valid  (pf_valid),
        .pf_ready  (pf_ready),
        .pf_addr   (pf_addr),
        .pf_to_llc (pf_to_llc),
        .wr_en     (wr_en),
        .wr_line   (wr_line),
        .wr_llc    (wr_llc)
    );

endmodule

// File: rtl/smp_checker.sv
module smp_checker #(
    parameter int ADDR_W = 32,
    parameter int DEGREE = 4,
    parameter int OCC_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_hit,
    input logic              req_was_pf,
    input logic [OCC_W-1:0]  mshr_occ,
    input logic              mark_valid,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr
);

    logic [ADDR_W-13:0] page_q;
    logic               quiet_q;
    logic [7:0]         taken_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q  <= '0;
            quiet_q <= 1'b0;
            taken_q <= '0;
        end else if (req_valid && req_ready) begin
            page_q  <= req_addr[ADDR_W-1:12];
            quiet_q <= req_hit && !req_was_pf;
            taken_q <= '0;
        end else if (pf_valid && pf_ready && taken_q != 8'hFF) begin
            taken_q <= taken_q + 1'b1;
        end
    end

    p_busy_blocks_req_r12: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> !req_ready);

    p_hold_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready && !mark_valid) ##1 $stable(mshr_occ) |-> (pf_valid && $stable(pf_addr)));

    p_same_page_r1: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> pf_addr[ADDR_W-1:12] == page_q);

    p_plain_hit_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        quiet_q |-> !pf_valid);

    p_degree_cap_r10: assert property (@(posedge clk) disable iff (rst)
        int'(taken_q) <= 2 * DEGREE);

endmodule

bind stride_map_prefetcher smp_checker #(
    .ADDR_W(ADDR_W), .DEGREE(DEGREE), .OCC_W(OCC_W)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_hit(req_hit), .req_was_pf(req_was_pf),
    .mshr_occ(mshr_occ), .mark_valid(mark_valid), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr)
);

// File: tb/stride_map_prefetcher_tb_top.sv
module stride_map_prefetcher_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 20;
    localparam int NP  = 4;
    localparam int DEG = 3;
    localparam int OW  = 6;
    localparam int PW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_hit = 1'b0;
    logic          req_was_pf = 1'b0;
    logic [PW-1:0] req_po_cnt = '0;
    logic [OW-1:0] mshr_occ = '0;
    logic          mark_valid = 1'b0;
    logic [AW-1:0] mark_addr = '0;
    logic          mark_page_ofs = 1'b0;
    logic          pf_valid;
    logic          pf_ready = 1'b1;
    logic [AW-1:0] pf_addr;
    logic          pf_to_llc;

    always #(CLK_PERIOD/2) clk = ~clk;

    stride_map_prefetcher #(
        .ADDR_W(AW), .N_PAGES(NP), .DEGREE(DEG), .OCC_W(OW), .PO_W(PW)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_hit(req_hit), .req_was_pf(req_was_pf),
        .req_po_cnt(req_po_cnt), .mshr_occ(mshr_occ), .mark_valid(mark_valid),
        .mark_addr(mark_addr), .mark_page_ofs(mark_page_ofs), .pf_valid(pf_valid),
        .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_to_llc(pf_to_llc)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit ready_random = 1'b0;
    int obs_q[$];
    int exp_q[$];

    // model state
    bit          m_valid [NP];
    int          m_tag   [NP];
    int          m_ts    [NP];
    int          stamp = 0;
    logic [63:0] m_acc [NP];
    logic [63:0] m_l2  [NP];
    logic [63:0] m_llc [NP];
    logic [63:0] m_lb  [NP];
    logic [63:0] m_po  [NP];

    always @(posedge clk) begin
        #1;
        pf_ready = ready_random ? ($urandom_range(0, 1) == 1) : 1'b1;
    end

    always @(negedge clk)
        if (!rst && pf_valid && pf_ready) obs_q.push_back(int'({pf_addr, pf_to_llc}));

    always @(posedge clk) begin
        cycles++;
        if (cycles > 180000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int find_page(int tag);
        for (int k = 0; k < NP; k++)
            if (m_valid[k] && m_tag[k] == tag) return k;
        return -1;
    endfunction

    // table model: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    task automatic model_req(int tag, int line, bit hit, bit wpf, int occ, int po);
        int e;
        int cap;
        e = find_page(tag);
        if (e < 0) begin
            for (int k = NP - 1; k >= 0; k--) if (!m_valid[k]) e = k;
            if (e < 0) begin
                e = 0;
                for (int k = 1; k < NP; k++) if (m_ts[k] < m_ts[e]) e = k;
            end
            m_valid[e] = 1'b1; m_tag[e] = tag;
            m_acc[e] = '0; m_l2[e] = '0; m_llc[e] = '0; m_lb[e] = '0; m_po[e] = '0;
        end
        m_ts[e] = stamp;
        stamp++;
        m_acc[e][line] = 1'b1;
        if (hit && !wpf) return;
        cap = DEG - po / 2;
        for (int d = 0; d < 2; d++) begin
            int cnt = 0;
            for (int i = 1; i <= 16; i++) begin
                int c, r1, r2;
                bit llc;
                c  = (d == 0) ? line + i : line - i;
                r1 = (d == 0) ? line - i : line + i;
                r2 = (d == 0) ? line - 2*i : line + 2*i;
                if (c < 0 || c > 63 || r2 < 0 || r2 > 63) break;
                if (cnt >= cap) break;
                if (!(m_acc[e][r1] && m_acc[e][r2]) || m_acc[e][c] || m_l2[e][c]) continue;
                if (m_po[e][c]) begin m_l2[e][c] = 1'b1; continue; end
                if (m_lb[e][c]) begin m_llc[e][c] = 1'b1; continue; end
                llc = occ >= 12;
                if (llc && m_llc[e][c]) continue;
                exp_q.push_back(((tag * 4096 + c * 64) << 1) | int'(llc));
                if (llc) m_llc[e][c] = 1'b1; else m_l2[e][c] = 1'b1;
                cnt++;
            end
        end
    endtask

    task automatic do_req(string rq, int tag, int line, bit hit, bit wpf, int occ, int po);
        int n;
        @(negedge clk);
        req_addr   = AW'(tag * 4096 + line * 64);
        req_hit    = hit;
        req_was_pf = wpf;
        mshr_occ   = OW'(occ);
        req_po_cnt = PW'(po);
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == !(!hit || wpf), "R12", "req_ready after accept", int'(req_ready), int'(hit && !wpf));
        model_req(tag, line, hit, wpf, occ, po);
        while (!(req_ready && !pf_valid)) @(negedge clk);
        check(obs_q.size() == exp_q.size(), rq, "prefetch count", obs_q.size(), exp_q.size());
        n = (obs_q.size() < exp_q.size()) ? obs_q.size() : exp_q.size();
        for (int k = 0; k < n; k++)
            check(obs_q[k] == exp_q[k], rq, "prefetch {addr,llc}", obs_q[k], exp_q[k]);
        obs_q.delete();
        exp_q.delete();
    endtask

    // R13: mark interface, 0 = large-block map, 1 = page-offset map
    task automatic do_mark(int tag, int line, bit po);
        int e;
        @(negedge clk);
        mark_addr     = AW'(tag * 4096 + line * 64);
        mark_page_ofs = po;
        mark_valid    = 1'b1;
        @(negedge clk);
        mark_valid = 1'b0;
        e = find_page(tag);
        if (e >= 0) begin
            if (po) m_po[e][line] = 1'b1; else m_lb[e][line] = 1'b1;
        end
    endtask

    initial begin
        for (int k = 0; k < NP; k++) m_valid[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R12", "reset req_ready", int'(req_ready), 1);
        check(pf_valid == 1'b0, "R12", "reset pf_valid", int'(pf_valid), 0);

        // R4 forward unit stride, L2 fills
        for (int l = 0; l < 6; l++) do_req("R4", 1, l, 1'b0, 1'b0, 0, 0);
        // R8 high occupancy sends fills to last-level cache
        for (int l = 0; l < 8; l += 2) do_req("R8", 2, l, 1'b0, 1'b0, 13, 0);
        // R9 LLC-marked candidate: skipped at high occupancy, L2 refill at low
        do_req("R9", 3, 0, 1'b0, 1'b0, 12, 0);
        do_req("R9", 3, 2, 1'b0, 1'b0, 12, 0);
        do_req("R9", 3, 4, 1'b0, 1'b0, 12, 0);
        do_req("R9", 3, 4, 1'b1, 1'b1, 12, 0);
        do_req("R9", 3, 4, 1'b1, 1'b1, 0, 0);
        // R5 backward stride
        for (int l = 40; l > 34; l--) do_req("R5", 4, l, 1'b0, 1'b0, 0, 0);
        // R3 plain hit issues nothing, prefetched hit does
        do_req("R3", 5, 0, 1'b0, 1'b0, 0, 0);
        do_req("R3", 5, 1, 1'b0, 1'b0, 0, 0);
        do_req("R3", 5, 2, 1'b1, 1'b0, 0, 0);
        do_req("R3", 5, 2, 1'b1, 1'b1, 0, 0);
        // R6 already-touched candidate is passed over
        do_req("R6", 5, 3, 1'b1, 1'b1, 0, 0);
        // R7 page-offset covered line absorbed, R13 marks
        do_req("R7", 6, 0, 1'b0, 1'b0, 0, 0);
        do_req("R7", 6, 1, 1'b0, 1'b0, 0, 0);
        do_mark(6, 3, 1'b1);
        do_mark(6, 4, 1'b0);
        do_mark(30, 2, 1'b1);
        do_req("R7", 6, 2, 1'b0, 1'b0, 0, 0);
        do_req("R8", 6, 3, 1'b0, 1'b0, 0, 0);
        do_req("R9", 6, 3, 1'b1, 1'b1, 0, 0);
        do_req("R13", 30, 0, 1'b0, 1'b0, 0, 0);
        do_req("R13", 30, 1, 1'b0, 1'b0, 0, 0);
        do_req("R13", 30, 2, 1'b1, 1'b1, 0, 0);
        // R10 degree cap with page-offset count
        for (int po = 0; po < 8; po += 2) begin
            for (int l = 0; l < 32; l++) do_req("R10", 7 + po, l, 1'b1, 1'b0, 0, 0);
            do_req("R10", 7 + po, 32, 1'b0, 1'b0, 0, po);
        end
        // R2 eviction clears maps
        for (int p = 40; p < 44; p++) begin
            do_req("R2", p, 0, 1'b0, 1'b0, 0, 0);
            do_req("R2", p, 1, 1'b0, 1'b0, 0, 0);
        end
        do_req("R2", 44, 0, 1'b0, 1'b0, 0, 0);
        do_req("R2", 40, 2, 1'b0, 1'b0, 0, 0);
        do_req("R2", 41, 2, 1'b0, 1'b0, 0, 0);
        // R11 random sweep with backpressure
        ready_random = 1'b1;
        for (int n = 0; n < 700; n++) begin
            if ($urandom_range(0, 7) == 0)
                do_mark(50 + $urandom_range(0, 5), $urandom_range(0, 63), $urandom_range(0, 1) == 1);
            do_req("R11", 50 + $urandom_range(0, 5), $urandom_range(0, 63),
                   $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
                   $urandom_range(0, 15), $urandom_range(0, 7));
        end
        ready_random = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule